// File: doc/BRIEF.md
# Multi-Channel DMA Request Controller

This block keeps the programming state of up to eight DMA channels and turns device transfer requests into transfer commands. Software programs each channel through a 32-bit register port: a spare mode word, a flags word (enable, direction and three status bits), a remaining byte count and a start address. Devices raise requests that each carry a direction and a wanted length. The controller serves one request per cycle, and the lowest channel number wins when several are pending.

For each served request, the controller first clears the channel's three status bits. It then checks that the channel is enabled and that the request direction matches the programmed one. A bad request sets a sticky memory-error status bit in the channel flags and the channel's bit in a shared error-source word. No command goes out for it. A good request produces one command for the translation stage on the next cycle. The command carries the channel address, the request length clamped to the remaining count, the direction and the channel number. The good request also sets the terminal-count status bit and lowers the count. Address translation, data movement and interrupt delivery belong to other blocks.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset every channel register reads zero, the error-source word reads zero, `cmd_valid` is low and `req_ready` is zero while no request is raised.
- R2: The register at byte address 0x100 + c*0x20 + r*8 belongs to channel c. The value r selects the register: 0 is the mode word, 1 the flags, 2 the count and 3 the address. The error-source word is read at 0x200, and writes to 0x200 are ignored. An address whose low three bits are nonzero, or that is not mapped, reads zero and is not written.
- R3: At most one request is served per cycle. `req_ready` is one-hot on the lowest-numbered channel with `req_valid` high, in the same cycle.
- R4: Serving a request first clears flag bits 8 (terminal count), 9 (memory error) and 10 (address error) of that channel. All other flag bits are kept.
- R5: A request to a channel whose flag bit 0 (enable) is clear is rejected. It sets flag bit 9 and error-source bit c, and issues no command.
- R6: `req_dir` = 1 means device-to-memory. Flag bit 1 set means memory-to-device. A request whose direction disagrees with bit 1 is rejected as in R5.
- R7: An accepted request raises `cmd_valid` for one cycle, on the cycle after the grant. The command carries `cmd_addr` equal to the channel address, `cmd_len` equal to min(requested length, count), `cmd_dir` equal to the request direction and `cmd_chan` equal to c. The request also sets flag bit 8.
- R8: An accepted request lowers the channel count by `cmd_len` and leaves the address register unchanged. A rejected request changes neither register.
- R9: Error-source bits only ever get set. Only reset clears them.
- R10: A register write to the flags or count of the channel being served in the same cycle is dropped in favour of the request update. A write to that channel's address or mode word still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | NCH | Per-channel request valid |
| req_dir | input | NCH | Per-channel request direction, 1 = device-to-memory |
| req_len | input | NCH*32 | Per-channel requested length, channel c at bits [c*32 +: 32] |
| req_ready | output | NCH | One-hot grant, same cycle |
| cmd_valid | output | 1 | Transfer command valid, one cycle |
| cmd_addr | output | 32 | Transfer start address |
| cmd_len | output | 32 | Clamped transfer length |
| cmd_dir | output | 1 | Transfer direction, 1 = device-to-memory |
| cmd_chan | output | 3 | Channel of the command |

## Verification
The bench builds the block with its defaults: NCH = 8 and AW = 10. Every channel is then reachable, including the highest one, and so is the full address map up to the error-source word. On every channel the bench sweeps all eight combinations of enable, programmed direction and request direction. It uses request lengths below, equal to and above the count, so that clamping and both kinds of rejection appear on each channel. Separate sequences cover simultaneous requests, same-cycle write collisions, ignored writes, unmapped reads and the clearing of the error-source word by a second reset.

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
  parameter int NCH = 8,
  parameter int AW  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NCH-1:0]    req_valid,
  input  logic [NCH-1:0]    req_dir,
  input  logic [NCH*32-1:0] req_len,
  output logic [NCH-1:0]    req_ready,
  output logic              cmd_valid,
  output logic [31:0]       cmd_addr,
  output logic [31:0]       cmd_len,
  output logic              cmd_dir,
  output logic [2:0]        cmd_chan
);
  localparam logic [31:0] ST_MASK = 32'h0000_0700;
  localparam logic [31:0] ST_TC   = 32'h0000_0100;
  localparam logic [31:0] ST_MERR = 32'h0000_0200;
  localparam int          ERR_SLOT = 'h200 >> 3;

  logic [31:0]    mode_q [NCH];
  logic [31:0]    flags_q[NCH];
  logic [31:0]    cnt_q  [NCH];
  logic [31:0]    addr_q [NCH];
  logic [NCH-1:0] errsrc_q;

  logic       gvalid;
  logic [2:0] gch;
  always_comb begin
    req_ready = '0;
    gch       = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_valid[i]) begin
        gch = 3'(i);
      end
    end
    gvalid = |req_valid;
    if (gvalid) req_ready[gch] = 1'b1;
  end

  logic [31:0] sel_flags, sel_cnt, sel_len, clen, nflags;
  logic        sel_dir, reject;
  assign sel_flags = flags_q[gch];
  assign sel_cnt   = cnt_q[gch];
  assign sel_len   = req_len[gch*32 +: 32];
  assign sel_dir   = req_dir[gch];
  assign reject    = !sel_flags[0] || (sel_dir == sel_flags[1]);
  assign clen      = (sel_len > sel_cnt) ? sel_cnt : sel_len;
  assign nflags    = (sel_flags & ~ST_MASK) | (reject ? ST_MERR : ST_TC);

  logic       aligned, in_chan, wr_chan;
  logic [2:0] ach;
  logic [1:0] areg;
  assign aligned = (reg_addr[2:0] == 3'd0);
  assign ach     = reg_addr[7:5];
  assign areg    = reg_addr[4:3];
  assign in_chan = aligned && (reg_addr[AW-1:8] == (AW-8)'(1)) && (int'(ach) < NCH);
  assign wr_chan = reg_we && in_chan;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic wsel, hit;
    assign wsel = wr_chan && (ach == 3'(c));
    assign hit  = gvalid && (gch == 3'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[c]  <= '0;
        flags_q[c] <= '0;
        cnt_q[c]   <= '0;
        addr_q[c]  <= '0;
      end else begin
        if (wsel && areg == 2'd0) mode_q[c] <= reg_wdata;
        if (wsel && areg == 2'd3) addr_q[c] <= reg_wdata;
        if (hit) begin
          flags_q[c] <= nflags;
          if (!reject) cnt_q[c] <= sel_cnt - clen;
        end else begin
          if (wsel && areg == 2'd1) flags_q[c] <= reg_wdata;
          if (wsel && areg == 2'd2) cnt_q[c]   <= reg_wdata;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      errsrc_q  <= '0;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_len   <= '0;
      cmd_dir   <= 1'b0;
      cmd_chan  <= '0;
    end else begin
      if (gvalid && reject) errsrc_q[gch] <= 1'b1;
      cmd_valid <= gvalid && !reject;
      if (gvalid && !reject) begin
        cmd_addr <= addr_q[gch];
        cmd_len  <= clen;
        cmd_dir  <= sel_dir;
        cmd_chan <= gch;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (in_chan) begin
      case (areg)
        2'd0:    reg_rdata = mode_q[ach];
        2'd1:    reg_rdata = flags_q[ach];
        2'd2:    reg_rdata = cnt_q[ach];
        default: reg_rdata = addr_q[ach];
      endcase
    end else if (aligned && int'(reg_addr[AW-1:3]) == ERR_SLOT) begin
      reg_rdata = 32'(errsrc_q);
    end
  end

  p_single_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));
  p_cmd_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gvalid && !reject) |=> cmd_valid);
  p_tc_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> flags_q[cmd_chan][8]);
  p_no_cmd_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gvalid && reject) |=> (!cmd_valid && errsrc_q != '0));
  p_errsrc_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((errsrc_q & $past(errsrc_q)) == $past(errsrc_q)));
endmodule

// File: tb/tb_dma_chan_ctrl.sv
module tb_dma_chan_ctrl;
  localparam int PER = 10;
  localparam int NCH = 8;
  localparam int AW  = 10;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NCH-1:0] req_valid = '0, req_dir = '0, req_ready;
  logic [NCH*32-1:0] req_len = '0;
  logic cmd_valid, cmd_dir;
  logic [31:0] cmd_addr, cmd_len;
  logic [2:0] cmd_chan;

  always #(PER/2) clk = ~clk;

  dma_chan_ctrl #(.NCH(NCH), .AW(AW)) dut (.*);

  int errors = 0, checks = 0;
  logic [31:0] m_md[NCH], m_fl[NCH], m_ct[NCH], m_ad[NCH];
  logic [NCH-1:0] m_err;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ra(int c, int r);
    return AW'('h100 + c * 'h20 + r * 8);
  endfunction

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic model_req(int c, logic dir, logic [31:0] len, output logic rej, output logic [31:0] l);
    logic [31:0] f;
    f = m_fl[c] & ~32'h700;
    rej = !f[0] || (dir == f[1]);
    l = 0;
    if (rej) begin
      f |= 32'h200; m_err[c] = 1'b1;
    end else begin
      f |= 32'h100;
      l = (len > m_ct[c]) ? m_ct[c] : len;
      m_ct[c] -= l;
    end
    m_fl[c] = f;
  endtask

  task automatic check_chan(int c);
    logic [31:0] v;
    rd(ra(c, 1), v); chk("R4/R5 flags", v, m_fl[c]);
    rd(ra(c, 2), v); chk("R8 count", v, m_ct[c]);
    rd(ra(c, 3), v); chk("R8 address", v, m_ad[c]);
    rd(AW'('h200), v); chk("R9 error source", v, 32'(m_err));
  endtask

  task automatic req(int c, logic dir, logic [31:0] len);
    logic rej;
    logic [31:0] l, a;
    a = m_ad[c];
    model_req(c, dir, len, rej, l);
    @(negedge clk);
    req_valid = NCH'(1) << c;
    req_dir = NCH'(dir) << c;
    req_len[c*32 +: 32] = len;
    #1 chk("R3 ready", 32'(req_ready), 32'(NCH'(1) << c));
    @(negedge clk);
    req_valid = '0;
    chk("R5/R6/R7 cmd_valid", 32'(cmd_valid), 32'(!rej));
    if (!rej) begin
      chk("R7 cmd_addr", cmd_addr, a);
      chk("R7 cmd_len", cmd_len, l);
      chk("R7 cmd_dir", 32'(cmd_dir), 32'(dir));
      chk("R7 cmd_chan", 32'(cmd_chan), 32'(c));
    end
    check_chan(c);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(PER * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    for (int c = 0; c < NCH; c++) begin
      m_md[c] = 0; m_fl[c] = 0; m_ct[c] = 0; m_ad[c] = 0;
    end
    m_err = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cmd_valid", 32'(cmd_valid), 0);
    chk("R1 ready", 32'(req_ready), 0);
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 4; r++) begin
        rd(ra(c, r), v); chk("R1 channel reg", v, 0);
      end
    rd(AW'('h200), v); chk("R1 error source", v, 0);

    // R2 mode word and map
    for (int c = 0; c < NCH; c++) begin
      m_md[c] = 32'hAB00 + c;
      wr(ra(c, 0), m_md[c]);
    end
    for (int c = 0; c < NCH; c++) begin
      rd(ra(c, 0), v); chk("R2 mode word", v, m_md[c]);
    end

    // R4-R8 sweep: enable x programmed dir x request dir, three length cases
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < 8; k++) begin
        logic [31:0] len;
        m_fl[c] = 32'h00F0_0700 | 32'(k & 1) | (32'((k >> 1) & 1) << 1);
        m_ct[c] = 100 + c * 16 + k;
        m_ad[c] = 32'h1000 * c + k * 4;
        wr(ra(c, 1), m_fl[c]);
        wr(ra(c, 2), m_ct[c]);
        wr(ra(c, 3), m_ad[c]);
        case (k % 3)
          0: len = m_ct[c] - 5;
          1: len = m_ct[c];
          default: len = m_ct[c] + 7;
        endcase
        req(c, logic'((k >> 2) & 1), len);
      end

    // R8 zero remaining count still accepted with zero length
    m_fl[4] = 32'h1; m_ct[4] = 0;
    wr(ra(4, 1), m_fl[4]); wr(ra(4, 2), 0);
    req(4, 1'b1, 32'd50);

    // R3 priority among simultaneous requests
    for (int c = 0; c < NCH; c++) begin
      m_fl[c] = 32'h1; m_ct[c] = 1000;
      wr(ra(c, 1), m_fl[c]); wr(ra(c, 2), m_ct[c]);
    end
    begin
      logic [NCH-1:0] pend;
      logic rej;
      logic [31:0] l;
      pend = 8'b1110_0100;
      @(negedge clk);
      req_valid = pend; req_dir = '1;
      for (int c = 0; c < NCH; c++) req_len[c*32 +: 32] = 32'(10 + c);
      while (pend != 0) begin
        int lo;
        lo = 0;
        for (int c = NCH - 1; c >= 0; c--) if (pend[c]) lo = c;
        #1 chk("R3 lowest wins", 32'(req_ready), 32'(NCH'(1) << lo));
        model_req(lo, 1'b1, 32'(10 + lo), rej, l);
        @(negedge clk);
        chk("R3 served channel", 32'(cmd_chan), 32'(lo));
        chk("R7 served length", cmd_len, l);
        pend[lo] = 1'b0;
        req_valid = pend;
      end
      for (int c = 0; c < NCH; c++) check_chan(c);
    end

    // R10 collisions on channel 3
    for (int t = 0; t < 3; t++) begin
      logic rej;
      logic [31:0] l, a;
      a = m_ad[3];
      model_req(3, 1'b1, 32'd20, rej, l);
      @(negedge clk);
      req_valid = 8'b0000_1000; req_dir = '1; req_len[3*32 +: 32] = 32'd20;
      reg_we = 1; reg_addr = ra(3, t + 1); reg_wdata = 32'h0000_0999;
      if (t == 2) m_ad[3] = 32'h0000_0999;
      @(negedge clk);
      req_valid = '0; reg_we = 0;
      chk("R10 cmd issued", 32'(cmd_valid), 1);
      chk("R10 cmd_addr old", cmd_addr, a);
      check_chan(3);
    end

    // R2 ignored write to error source, unmapped and unaligned reads
    wr(AW'('h200), 32'hFFFF_FFFF);
    rd(AW'('h200), v); chk("R2 error source write ignored", v, 32'(m_err));
    rd(AW'('h210), v); chk("R2 unmapped read", v, 0);
    rd(AW'('h008), v); chk("R2 low region read", v, 0);
    wr(ra(2, 0) + AW'(4), 32'h5555);
    rd(ra(2, 0), v); chk("R2 unaligned write ignored", v, m_md[2]);

    // R9 only reset clears the error source
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(AW'('h200), v); chk("R9 cleared by reset", v, 0);
    rd(ra(6, 2), v); chk("R1 count after reset", v, 0);
    finish_run();
  end
endmodule